// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is a serial slave that lets an external host read and write a bank of byte-wide configuration registers through four wires: a serial clock, an active-low select, a data input and a data output. Each transaction starts when the select goes low and ends when it goes high. The first byte the host sends is a command, the second is a starting register address, and every later byte is data. The address moves up by one after each data byte, so one transaction covers a run of consecutive registers.

The command chooses the direction of transfer. It also chooses between a counted mode and an open-ended streaming mode. In counted mode a three-bit field gives the number of data bytes. Once that many bytes have been handled, the rest of the transaction is ignored. In streaming mode the block keeps transferring until the select rises. The serial pins are sampled in the block's system clock domain, and the host is assumed to drive them synchronously to that clock. A register array model with a simple synchronous write port and a combinational read port sits behind the serial engine.

Top module: `spi_regacc`

## Requirements
- R1: After reset, and in the cycle after the select is seen high, the data-output enable is low. All registers reset to 0x00.
- R2: Bits travel MSB first in SPI mode 0. The data input is captured on a rising serial clock. The data output changes only after a falling serial clock.
- R3: A command with bits [7:6] = 2'b10 is a counted write. Bits [5:3] give the byte count n, where 3'b000 means 8. Bits [2:0] are don't care.
- R4: In a counted write, only the first n complete data bytes are written. The registers after address+n-1 keep their values, whatever further bytes arrive.
- R5: Command 0xC0 (bits [7:6] = 2'b11, bits [5:3] = 3'b000) is a streaming write. Every complete data byte is written until the select rises.
- R6: Command 0x40 (bits [7:6] = 2'b01, bits [5:3] = 3'b000) is a streaming read. It returns consecutive registers until the select rises.
- R7: A command with bits [7:6] = 2'b01 and a nonzero count n in bits [5:3] is a counted read. It returns n registers, then zero bytes with the output enable low.
- R8: The address steps by one after each data byte and wraps from 0xFF to 0x00. Reads at or above NUM_REGS return 0x00, and writes there are dropped.
- R9: A data byte is written only after all 8 of its bits have arrived. A transaction cut short leaves no register changed by the partial byte, and the next transaction starts with a command byte.
- R10: Any other command value (bits [7:6] = 2'b00, or 2'b11 with a nonzero count) causes the rest of the transaction to be ignored. No register changes and the output stays low.
- R11: The output enable is high only during the data bytes of a read. The data output is low whenever the enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| csb | input | 1 | Active-low transaction select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_en | output | 1 | High while a read data byte is being shifted out |

## Verification
A serial clock edge is seen on the first system clock edge after the pin changes. The output shift register updates on that same edge, so sdo is settled one system clock after a falling sck. A data byte is written on the edge that sees its eighth rising sck. The bench holds each sck level for four system clocks and reads sdo and sdo_en at a falling clk edge just before it raises sck, well after the one-cycle update. It checks writes only through later serial reads, started after the select has been high for several cycles.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam int REM_W   = CNT_W + 1;
    localparam int DIR_LSB = 6;
    localparam int NUM_LSB = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_WDATA = 3'd2,
        PH_RDATA = 3'd3,
        PH_SKIP  = 3'd4
    } phase_e;

    typedef struct packed {
        logic              sck_q;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-2:0] rx;
        byte_t             tx;
    } shift_s;

    typedef struct packed {
        phase_e            phase;
        logic              is_wr;
        logic              stream;
        logic [REM_W-1:0]  rem;
        byte_t             addr;
    } ctrl_s;

endpackage

// File: rtl/spi_regacc_shift.sv
module spi_regacc_shift
    import spi_regacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sck,
    input  logic  csb,
    input  logic  sdi,
    input  logic  tx_load,
    input  byte_t tx_data,
    output logic  byte_done,
    output byte_t rx_byte,
    output logic  byte_start,
    output logic  sdo_bit
);

    localparam logic [CNT_W-1:0] LAST_BIT = '1;

    shift_s q, d;
    logic   rise, fall;

    always_comb begin
        d      = q;
        rise   = !csb && sck && !q.sck_q;
        fall   = !csb && !sck && q.sck_q;
        d.sck_q = sck;
        if (csb) begin
            d.bit_cnt = '0;
            d.rx      = '0;
            d.tx      = '0;
        end else begin
            if (rise) begin
                d.rx      = {q.rx[BYTE_W-3:0], sdi};
                d.bit_cnt = q.bit_cnt + 1'b1;
            end
            if (fall) begin
                d.tx = tx_load ? tx_data : {q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign byte_done  = rise && (q.bit_cnt == LAST_BIT);
    assign rx_byte    = {q.rx, sdi};
    assign byte_start = fall && (q.bit_cnt == '0);
    assign sdo_bit    = q.tx[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/spi_regacc_ctrl.sv
module spi_regacc_ctrl
    import spi_regacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  csb,
    input  logic  byte_done,
    input  byte_t rx_byte,
    input  logic  byte_start,
    output logic  wr_en,
    output byte_t wr_addr,
    output byte_t wr_data,
    output byte_t rd_addr,
    output logic  tx_load,
    output logic  rd_active
);

    localparam logic [REM_W-1:0] REM_FULL = REM_W'(BYTE_W);
    localparam logic [REM_W-1:0] REM_ONE  = REM_W'(1);

    ctrl_s            q, d;
    logic [1:0]       cmd_dir;
    logic [CNT_W-1:0] cmd_num;

    assign cmd_dir = rx_byte[DIR_LSB +: 2];
    assign cmd_num = rx_byte[NUM_LSB +: CNT_W];

    always_comb begin
        d         = q;
        wr_en     = 1'b0;
        wr_addr   = q.addr;
        wr_data   = rx_byte;
        rd_addr   = q.addr;
        rd_active = (q.phase == PH_RDATA);
        tx_load   = byte_start && (q.phase == PH_RDATA);
        if (csb) begin
            d = '0;
        end else if (byte_done) begin
            case (q.phase)
                PH_CMD: begin
                    d.phase  = PH_ADDR;
                    d.is_wr  = 1'b0;
                    d.stream = 1'b0;
                    d.rem    = {1'b0, cmd_num};
                    case (cmd_dir)
                        2'b10: begin
                            d.is_wr = 1'b1;
                            if (cmd_num == '0) d.rem = REM_FULL;
                        end
                        2'b11: begin
                            if (cmd_num == '0) begin
                                d.is_wr  = 1'b1;
                                d.stream = 1'b1;
                            end else begin
                                d.phase = PH_SKIP;
                            end
                        end
                        2'b01:   d.stream = (cmd_num == '0);
                        default: d.phase  = PH_SKIP;
                    endcase
                end
                PH_ADDR: begin
                    d.addr  = rx_byte;
                    d.phase = q.is_wr ? PH_WDATA : PH_RDATA;
                end
                PH_WDATA, PH_RDATA: begin
                    wr_en  = (q.phase == PH_WDATA);
                    d.addr = q.addr + 1'b1;
                    if (!q.stream) begin
                        d.rem = q.rem - 1'b1;
                        if (q.rem == REM_ONE) d.phase = PH_SKIP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/spi_regacc_regs.sv
module spi_regacc_regs
    import spi_regacc_pkg::*;
#(
    parameter int NUM_REGS = 128
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wr_addr,
    input  byte_t wr_data,
    input  byte_t rd_addr,
    output byte_t rd_data
);

    localparam int              IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'(NUM_REGS);

    byte_t mem_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        byte_t mem_d;
        always_comb begin
            mem_d = mem_q[i];
            if (wr_en && ({1'b0, wr_addr} == (BYTE_W+1)'(i))) mem_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d;
        end
    end

    assign rd_data = ({1'b0, rd_addr} < LIMIT) ? mem_q[rd_addr[IDX_W-1:0]] : '0;

endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
    import spi_regacc_pkg::*;
#(
    parameter int NUM_REGS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic csb,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);

    logic  byte_done, byte_start, tx_load, rd_active, sdo_bit;
    logic  reg_we;
    byte_t rx_byte, reg_waddr, reg_wdata, reg_raddr, reg_rdata;

    spi_regacc_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (sck),
        .csb        (csb),
        .sdi        (sdi),
        .tx_load    (tx_load),
        .tx_data    (reg_rdata),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .byte_start (byte_start),
        .sdo_bit    (sdo_bit)
    );

    spi_regacc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .csb        (csb),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .byte_start (byte_start),
        .wr_en      (reg_we),
        .wr_addr    (reg_waddr),
        .wr_data    (reg_wdata),
        .rd_addr    (reg_raddr),
        .tx_load    (tx_load),
        .rd_active  (rd_active)
    );

    spi_regacc_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_addr (reg_waddr),
        .wr_data (reg_wdata),
        .rd_addr (reg_raddr),
        .rd_data (reg_rdata)
    );

    assign sdo_en = rd_active && !csb;
    assign sdo    = sdo_en && sdo_bit;

endmodule

// File: rtl/spi_regacc_checker.sv
module spi_regacc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       csb,
    input logic       sdo,
    input logic       sdo_en,
    input logic       wr_en,
    input logic [7:0] wr_addr
);

    logic       sck_p;
    logic       have_last;
    logic [7:0] last_addr;
    logic       fall_c;

    assign fall_c = sck_p && !sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p     <= 1'b0;
            have_last <= 1'b0;
            last_addr <= '0;
        end else begin
            sck_p <= sck;
            if (csb) begin
                have_last <= 1'b0;
            end else if (wr_en) begin
                have_last <= 1'b1;
                last_addr <= wr_addr;
            end
        end
    end

    // R1: a high select clears the read phase by the next cycle
    p_csb_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        csb |=> !sdo_en);

    // R2: the output moves only after a falling serial clock
    p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && $past(sdo_en) && !$past(fall_c)) |-> $stable(sdo));

    // R9: a commit happens only on a fresh rising serial clock inside a transaction
    p_commit_at_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!csb && sck && !sck_p));

    // R4: at most one commit per received byte
    p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R8: successive commits in a transaction go to successive addresses
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && have_last) |-> (wr_addr == 8'(last_addr + 8'd1)));

endmodule

bind spi_regacc spi_regacc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck     (sck),
    .csb     (csb),
    .sdo     (sdo),
    .sdo_en  (sdo_en),
    .wr_en   (reg_we),
    .wr_addr (reg_waddr)
);

// File: tb/spi_regacc_test.sv
module spi_regacc_test;

    localparam int NREG = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic csb = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] model [256];

    always #5 clk = ~clk;

    spi_regacc #(.NUM_REGS(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL R2 watchdog: act=%0d cycles exp<190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic sel;
        tick(2); csb = 1'b0; tick(4);
    endtask

    task automatic desel;
        tick(4); csb = 1'b1; tick(6);
    endtask

    task automatic bits(input logic [7:0] v, input int nb, output logic [7:0] rx, output logic en);
        rx = '0; en = 1'b0;
        for (int i = 7; i > 7 - nb; i--) begin
            sdi = v[i];
            tick(4);
            rx[i] = sdo;
            en = en | sdo_en;
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
        end
    endtask

    function automatic logic [7:0] expect_at(input int a);
        return (a < NREG) ? model[a] : 8'h00;
    endfunction

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] addr, input int cnt,
                            input logic [7:0] seed, input int commit, input string req);
        logic [7:0] rx;
        logic en;
        sel();
        bits(cmd, 8, rx, en);
        bits(addr, 8, rx, en);
        for (int i = 0; i < cnt; i++) begin
            logic [7:0] v;
            int a;
            v = 8'(seed + i * 37);
            a = (addr + i) & 8'hFF;
            bits(v, 8, rx, en);
            chk({req, " R11 write-phase enable"}, en, 0);
            if (i < commit && a < NREG) model[a] = v;
        end
        desel();
    endtask

    task automatic do_read(input logic [7:0] cmd, input logic [7:0] addr, input int cnt,
                           input int nvalid, input string req);
        logic [7:0] rx;
        logic en;
        sel();
        bits(cmd, 8, rx, en);
        bits(addr, 8, rx, en);
        for (int i = 0; i < cnt; i++) begin
            int a;
            a = (addr + i) & 8'hFF;
            bits(8'h00, 8, rx, en);
            chk(req, rx, (i < nvalid) ? expect_at(a) : 0);
            chk({req, " R11 read enable"}, en, (i < nvalid) ? 1 : 0);
        end
        desel();
    endtask

    initial begin
        logic [7:0] rx;
        logic en;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        tick(5);
        chk("R1 sdo at reset", sdo, 0);
        chk("R1 sdo_en at reset", sdo_en, 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 sdo_en idle", sdo_en, 0);
        do_read(8'h40, 8'h00, 4, 4, "R1 reset value R6");

        // R2: single counted write of an asymmetric byte
        do_write(8'h88, 8'h40, 1, 8'h81, 1, "R2");
        do_read(8'h40, 8'h40, 1, 1, "R2 MSB-first readback");

        // R3 R4 R5 R6: counted writes over every n, two base addresses
        for (int b = 0; b < 2; b++) begin
            for (int n = 1; n <= 8; n++) begin
                logic [7:0] base, cmd;
                base = (b == 0) ? 8'h26 : 8'h5E;
                cmd  = {2'b10, 3'(n), 3'b101};
                do_write(8'hC0, base, 10, 8'(8'h1F + n + b), 10, "R5");
                do_write(cmd, base, 10, 8'(8'hA3 ^ n), n, "R3");
                do_read(8'h40, base, 10, 10, "R4 R6");
            end
        end

        // R7: counted reads
        for (int n = 1; n <= 7; n++) begin
            do_read({2'b01, 3'(n), 3'b000}, 8'h26, n + 2, n, "R7");
        end

        // R8: address wrap and unmapped addresses
        do_write(8'hC0, 8'hFE, 4, 8'h6C, 4, "R8");
        do_read(8'h40, 8'h7E, 4, 4, "R8 unmapped read");
        do_read(8'h40, 8'hFF, 3, 3, "R8 wrap read");

        // R9: byte cut short
        sel();
        bits(8'hC0, 8, rx, en);
        bits(8'h10, 8, rx, en);
        bits(8'h55, 5, rx, en);
        desel();
        do_read(8'h40, 8'h10, 1, 1, "R9 partial data");
        sel();
        bits(8'h80, 3, rx, en);
        desel();
        do_write(8'hC0, 8'h11, 1, 8'h3C, 1, "R9");
        do_read(8'h40, 8'h11, 1, 1, "R9 fresh command");

        // R10: unrecognised commands
        for (int k = 0; k < 4; k++) begin
            logic [7:0] cmd;
            case (k)
                0: cmd = 8'h00;
                1: cmd = 8'h3F;
                2: cmd = 8'hC8;
                default: cmd = 8'hF8;
            endcase
            sel();
            bits(cmd, 8, rx, en);
            bits(8'h30, 8, rx, en);
            for (int i = 0; i < 3; i++) begin
                bits(8'hAA, 8, rx, en);
                chk("R10 sdo quiet", rx, 0);
                chk("R10 R11 enable low", en, 0);
            end
            desel();
            do_read(8'h40, 8'h30, 3, 3, "R10 registers intact");
        end

        chk("R1 sdo_en after run", sdo_en, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule